// File: doc/BRIEF.md
# Time Code Frame Decoder

This block sits after a pulse-width classifier. It takes a stream of time-code characters (zero, one, position marker, idle) and finds where each frame starts. A frame starts at a marker that comes directly after another marker. That reference marker gives a one-cycle on-time pulse. The 99 characters that follow are written into the fill half of a two-bank frame store, while the other half keeps the last accepted frame.

When the final character of a frame has been written, the frame is checked against a marker table computed from the parameters. Its BCD time digits are also range-checked. A frame that passes swaps the banks, loads seconds, minutes, hours and day of year into the output registers as binary values, and raises a one-cycle frame-valid strobe. A frame that fails leaves the outputs and banks as they were. Alignment is handled by an enumerated state machine with these states:
- `ST_HUNT`: waiting for any marker.
- `ST_ONE_MARK`: one marker has been seen.
- `ST_COLLECT`: writing frame positions.

It has these transitions:
- HUNT→ONE_MARK on a marker.
- ONE_MARK→COLLECT on a marker, which is the reference and fires the on-time pulse.
- ONE_MARK→HUNT on any other character.
- COLLECT→HUNT on idle.
- COLLECT at the last position goes to ONE_MARK if that character is a marker, and to HUNT otherwise.

Top module: `tcfd_frame_decoder`

## Requirements
- R1: After reset, on_time, frame_valid, time_valid, held_bank and all time outputs are 0.
- R2: sym_code is sampled only when sym_valid is 1, with the codes 0 = zero, 1 = one, 2 = marker and 3 = idle. A marker sampled directly after another sampled marker is the reference (position 0). on_time is 1 for exactly the cycle after the clock edge that samples it. A non-marker between two markers cancels the pairing.
- R3: The characters after the reference are positions 1 to 99. A marker must appear at every position p with p mod 10 = 9, and at no other position. Any mismatch discards the frame: no strobe, and the outputs and held_bank keep their values.
- R4: Time fields are BCD and sent least significant bit first, where a one character is bit value 1:
  - seconds: units at positions 1–4, tens at 6–8
  - minutes: units at 10–13, tens at 15–17
  - hours: units at 20–23, tens at 25–26
  - day: units at 30–33, tens at 35–38, hundreds at 40–41

  The outputs give the binary values. Characters at positions outside these fields and the markers have no effect.
- R5: The frame is discarded if any of these holds:
  - a units digit or the day tens digit is above 9
  - seconds or minutes are above 59
  - hours are above 23
  - the day is 0 or above 366
- R6: For an accepted frame, frame_valid is 1 for one cycle, beginning two clock edges after the edge that samples position 99. In that same cycle the time outputs update and held_bank toggles. time_valid becomes 1 and stays 1. At no other time do held_bank or the time outputs change.
- R7: An idle character during collection abandons the frame and restarts the hunt. Idle while hunting has no effect.
- R8: When position 99 is a marker, the next sampled marker is taken directly as the following reference, so back-to-back frames align with no extra marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | A character is present this cycle |
| sym_code | input | 2 | Character code: 0 zero, 1 one, 2 marker, 3 idle |
| on_time | output | 1 | One-cycle pulse for the reference marker |
| frame_valid | output | 1 | One-cycle strobe when a frame is accepted |
| time_valid | output | 1 | Set after the first accepted frame |
| held_bank | output | 1 | Index of the bank holding the last accepted frame |
| seconds | output | 6 | Decoded seconds, binary |
| minutes | output | 6 | Decoded minutes, binary |
| hours | output | 5 | Decoded hours, binary |
| day_of_year | output | 9 | Decoded day of year, binary |

## Verification
The frames are sent with three character spacings: several idle cycles, one idle cycle, and back to back. These spacings separate the fixed strobe latency from any dependence on the arrival rate. Stray ones and single markers before the first frame show that only a true marker pair aligns. Chained frames show that the final marker is reused as the next reference. Frames with a missing marker, an extra marker, and each kind of out-of-range digit, including day 0 and day 367, must leave the outputs and bank unchanged. An idle character mid-frame must abandon the frame. A reference model in the bench is compared with every output on every cycle.

// File: rtl/tcfd_pkg.sv
package tcfd_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_ONE  = 2'd1,
        SYM_MARK = 2'd2,
        SYM_IDLE = 2'd3
    } sym_e;

    localparam int FRAME_LEN_DEF = 100;
    localparam int MARK_GAP_DEF  = 10;

    // Field start positions (element index within the frame), LSB first
    localparam int SEC_U_POS = 1;
    localparam int SEC_T_POS = 6;
    localparam int MIN_U_POS = 10;
    localparam int MIN_T_POS = 15;
    localparam int HR_U_POS  = 20;
    localparam int HR_T_POS  = 25;
    localparam int DAY_U_POS = 30;
    localparam int DAY_T_POS = 35;
    localparam int DAY_H_POS = 40;

    localparam int UNIT_W  = 4;
    localparam int SEC_T_W = 3;
    localparam int MIN_T_W = 3;
    localparam int HR_T_W  = 2;
    localparam int DAY_T_W = 4;
    localparam int DAY_H_W = 2;

endpackage

// File: rtl/tcfd_align.sv
module tcfd_align
    import tcfd_pkg::*;
#(
    parameter int  FRAME_LEN = FRAME_LEN_DEF,
    localparam int POS_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic [1:0]       sym_code,
    output logic             on_time,
    output logic             wr_en,
    output logic [POS_W-1:0] wr_pos,
    output logic             frame_done
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,
        ST_ONE_MARK = 2'd1,
        ST_COLLECT  = 2'd2
    } align_st_e;

    align_st_e        st_q, st_d;
    logic [POS_W-1:0] pos_q, pos_d;
    sym_e             code;
    logic             is_mark;
    logic             on_time_q, done_q;

    assign code    = sym_e'(sym_code);
    assign is_mark = (code == SYM_MARK);

    // next-state logic
    always_comb begin
        st_d  = st_q;
        pos_d = pos_q;
        if (sym_valid) begin
            unique case (st_q)
                ST_HUNT: begin
                    if (is_mark) st_d = ST_ONE_MARK;
                end
                ST_ONE_MARK: begin
                    if (is_mark) begin
                        st_d  = ST_COLLECT;
                        pos_d = POS_W'(1);
                    end else begin
                        st_d = ST_HUNT;
                    end
                end
                ST_COLLECT: begin
                    if (code == SYM_IDLE) begin
                        st_d = ST_HUNT;
                    end else if (pos_q == LAST_POS) begin
                        st_d = is_mark ? ST_ONE_MARK : ST_HUNT;
                    end else begin
                        pos_d = pos_q + POS_W'(1);
                    end
                end
                default: st_d = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_HUNT;
            pos_q <= '0;
        end else begin
            st_q  <= st_d;
            pos_q <= pos_d;
        end
    end

    // outputs
    assign wr_en  = sym_valid && (st_q == ST_COLLECT) && (code != SYM_IDLE);
    assign wr_pos = pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_time_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            on_time_q <= sym_valid && (st_q == ST_ONE_MARK) && is_mark;
            done_q    <= wr_en && (pos_q == LAST_POS);
        end
    end

    assign on_time    = on_time_q;
    assign frame_done = done_q;

    AST_ONTIME_FROM_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        on_time |-> ($past(sym_valid) && $past(sym_code) == SYM_MARK)); // R2

    AST_POS_IN_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COLLECT) |-> (pos_q >= POS_W'(1) && pos_q <= LAST_POS)); // R3

    AST_IDLE_NEVER_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (sym_code != SYM_IDLE)); // R7

endmodule

// File: rtl/tcfd_store.sv
module tcfd_store
    import tcfd_pkg::*;
#(
    parameter int  FRAME_LEN = FRAME_LEN_DEF,
    localparam int POS_W     = $clog2(FRAME_LEN),
    localparam int BODY      = FRAME_LEN - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [POS_W-1:0]  wr_pos,
    input  logic [1:0]        wr_code,
    input  logic              swap,
    output logic              held_bank,
    output logic [2*BODY-1:0] fill_codes
);

    logic [1:0]       mem_q [2][BODY];
    logic             bank_q;
    logic             fill_bank;
    logic [POS_W-1:0] wr_idx;

    assign fill_bank = ~bank_q;
    assign wr_idx    = wr_pos - POS_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= 1'b0;
            for (int b = 0; b < 2; b++) begin
                for (int p = 0; p < BODY; p++) begin
                    mem_q[b][p] <= 2'd0;
                end
            end
        end else begin
            if (swap) bank_q <= ~bank_q;
            if (wr_en) mem_q[fill_bank][wr_idx] <= wr_code;
        end
    end

    for (genvar p = 0; p < BODY; p++) begin : g_rd
        assign fill_codes[2*p +: 2] = mem_q[fill_bank][p];
    end

    assign held_bank = bank_q;

    AST_WR_POS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_pos != '0 && int'(wr_pos) < FRAME_LEN)); // R3

    AST_NO_WR_AT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        swap |-> !wr_en); // R6

endmodule

// File: rtl/tcfd_check.sv
module tcfd_check
    import tcfd_pkg::*;
#(
    parameter int  FRAME_LEN = FRAME_LEN_DEF,
    parameter int  MARK_GAP  = MARK_GAP_DEF,
    localparam int BODY      = FRAME_LEN - 1
) (
    input  logic [2*BODY-1:0] codes,
    output logic              chk_ok,
    output logic [5:0]        sec,
    output logic [5:0]        min,
    output logic [4:0]        hr,
    output logic [8:0]        day
);

    // table: bit p-1 set when position p must hold a marker
    function automatic logic [BODY-1:0] mark_table();
        logic [BODY-1:0] t;
        for (int p = 1; p <= BODY; p++) begin
            t[p-1] = ((p % MARK_GAP) == MARK_GAP - 1);
        end
        return t;
    endfunction

    localparam logic [BODY-1:0] MARK_TABLE = mark_table();

    function automatic int fld(input logic [2*BODY-1:0] c, input int pos, input int w);
        int v;
        v = 0;
        for (int i = 0; i < w; i++) begin
            if (c[2*(pos-1+i) +: 2] == SYM_ONE) v = v + (1 << i);
        end
        return v;
    endfunction

    logic [BODY-1:0] mism;

    for (genvar p = 0; p < BODY; p++) begin : g_tab
        assign mism[p] = (codes[2*p +: 2] == SYM_MARK) ^ MARK_TABLE[p];
    end

    int sec_u, sec_t, min_u, min_t, hr_u, hr_t, day_u, day_t, day_h;
    int sec_v, min_v, hr_v, day_v;
    logic digits_ok;

    assign sec_u = fld(codes, SEC_U_POS, UNIT_W);
    assign sec_t = fld(codes, SEC_T_POS, SEC_T_W);
    assign min_u = fld(codes, MIN_U_POS, UNIT_W);
    assign min_t = fld(codes, MIN_T_POS, MIN_T_W);
    assign hr_u  = fld(codes, HR_U_POS, UNIT_W);
    assign hr_t  = fld(codes, HR_T_POS, HR_T_W);
    assign day_u = fld(codes, DAY_U_POS, UNIT_W);
    assign day_t = fld(codes, DAY_T_POS, DAY_T_W);
    assign day_h = fld(codes, DAY_H_POS, DAY_H_W);

    assign sec_v = sec_t * 10 + sec_u;
    assign min_v = min_t * 10 + min_u;
    assign hr_v  = hr_t * 10 + hr_u;
    assign day_v = day_h * 100 + day_t * 10 + day_u;

    assign digits_ok = (sec_u <= 9) && (sec_v <= 59)
                    && (min_u <= 9) && (min_v <= 59)
                    && (hr_u  <= 9) && (hr_v  <= 23)
                    && (day_u <= 9) && (day_t <= 9)
                    && (day_v >= 1) && (day_v <= 366);

    assign chk_ok = digits_ok && (mism == '0);
    assign sec    = 6'(sec_v);
    assign min    = 6'(min_v);
    assign hr     = 5'(hr_v);
    assign day    = 9'(day_v);

endmodule

// File: rtl/tcfd_frame_decoder.sv
module tcfd_frame_decoder
    import tcfd_pkg::*;
#(
    parameter int  FRAME_LEN = FRAME_LEN_DEF,
    parameter int  MARK_GAP  = MARK_GAP_DEF,
    localparam int POS_W     = $clog2(FRAME_LEN),
    localparam int BODY      = FRAME_LEN - 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid,
    input  logic [1:0] sym_code,
    output logic       on_time,
    output logic       frame_valid,
    output logic       time_valid,
    output logic       held_bank,
    output logic [5:0] seconds,
    output logic [5:0] minutes,
    output logic [4:0] hours,
    output logic [8:0] day_of_year
);

    logic              wr_en;
    logic [POS_W-1:0]  wr_pos;
    logic              frame_done;
    logic [2*BODY-1:0] fill_codes;
    logic              chk_ok;
    logic [5:0]        c_sec, c_min;
    logic [4:0]        c_hr;
    logic [8:0]        c_day;
    logic              swap;

    logic       fv_q, tv_q;
    logic [5:0] sec_q, min_q;
    logic [4:0] hr_q;
    logic [8:0] day_q;

    tcfd_align #(.FRAME_LEN(FRAME_LEN)) u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .sym_valid  (sym_valid),
        .sym_code   (sym_code),
        .on_time    (on_time),
        .wr_en      (wr_en),
        .wr_pos     (wr_pos),
        .frame_done (frame_done)
    );

    tcfd_store #(.FRAME_LEN(FRAME_LEN)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_pos     (wr_pos),
        .wr_code    (sym_code),
        .swap       (swap),
        .held_bank  (held_bank),
        .fill_codes (fill_codes)
    );

    tcfd_check #(.FRAME_LEN(FRAME_LEN), .MARK_GAP(MARK_GAP)) u_check (
        .codes  (fill_codes),
        .chk_ok (chk_ok),
        .sec    (c_sec),
        .min    (c_min),
        .hr     (c_hr),
        .day    (c_day)
    );

    assign swap = frame_done && chk_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fv_q  <= 1'b0;
            tv_q  <= 1'b0;
            sec_q <= '0;
            min_q <= '0;
            hr_q  <= '0;
            day_q <= '0;
        end else begin
            fv_q <= swap;
            if (swap) begin
                tv_q  <= 1'b1;
                sec_q <= c_sec;
                min_q <= c_min;
                hr_q  <= c_hr;
                day_q <= c_day;
            end
        end
    end

    assign frame_valid = fv_q;
    assign time_valid  = tv_q;
    assign seconds     = sec_q;
    assign minutes     = min_q;
    assign hours       = hr_q;
    assign day_of_year = day_q;

    AST_FV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid); // R6

    AST_BANK_WITH_FV: assert property (@(posedge clk) disable iff (!rst_n)
        (held_bank != $past(held_bank)) |-> frame_valid); // R6

    AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> ($stable(seconds) && $stable(minutes)
                          && $stable(hours) && $stable(day_of_year))); // R3

    AST_TV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        time_valid |=> time_valid); // R6

    AST_TIME_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        time_valid |-> (seconds <= 6'd59 && minutes <= 6'd59 && hours <= 5'd23
                        && day_of_year >= 9'd1 && day_of_year <= 9'd366)); // R5

endmodule

// File: tb/tcfd_frame_decoder_bench.sv
`timescale 1ns/1ps
module tcfd_frame_decoder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_valid = 1'b0;
    logic [1:0] sym_code = 2'd0;
    logic       on_time, frame_valid, time_valid, held_bank;
    logic [5:0] seconds, minutes;
    logic [4:0] hours;
    logic [8:0] day_of_year;

    always #2 clk = ~clk;

    tcfd_frame_decoder u_tcfd_frame_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym_valid   (sym_valid),
        .sym_code    (sym_code),
        .on_time     (on_time),
        .frame_valid (frame_valid),
        .time_valid  (time_valid),
        .held_bank   (held_bank),
        .seconds     (seconds),
        .minutes     (minutes),
        .hours       (hours),
        .day_of_year (day_of_year)
    );

    int checks = 0;
    int failures = 0;
    int gap = 2;
    int fv_seen = 0;
    int ont_seen = 0;
    int cycles = 0;
    int frm [100];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int  m_st = 0;            // 0 hunting, 1 one marker seen, 2 collecting
    int  q[$];                // positions 1.. of the current frame
    bit  m_pend = 0, m_pend_ok = 0;
    int  p_s, p_m, p_h, p_d;
    bit  e_ont = 0, e_fv = 0, e_tv = 0, e_bank = 0;
    int  e_s = 0, e_m = 0, e_h = 0, e_d = 0;

    function automatic int qf(int pos, int w);
        int v = 0;
        for (int i = 0; i < w; i++) if (q[pos-1+i] == 1) v += (1 << i);
        return v;
    endfunction

    task automatic evaluate();
        int su, st, mu, mt, hu, ht, du, dt, dh;
        bit ok = 1;
        for (int p = 1; p <= 99; p++) begin
            if ((q[p-1] == 2) != ((p % 10) == 9)) ok = 0;
        end
        su = qf(1, 4); st = qf(6, 3); mu = qf(10, 4); mt = qf(15, 3);
        hu = qf(20, 4); ht = qf(25, 2); du = qf(30, 4); dt = qf(35, 4); dh = qf(40, 2);
        p_s = st * 10 + su; p_m = mt * 10 + mu; p_h = ht * 10 + hu;
        p_d = dh * 100 + dt * 10 + du;
        if (su > 9 || mu > 9 || hu > 9 || du > 9 || dt > 9) ok = 0;
        if (p_s > 59 || p_m > 59 || p_h > 23 || p_d < 1 || p_d > 366) ok = 0;
        m_pend_ok = ok;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; q.delete(); m_pend = 0;
            e_ont = 0; e_fv = 0; e_tv = 0; e_bank = 0;
            e_s = 0; e_m = 0; e_h = 0; e_d = 0;
        end else begin
            e_ont = 0;
            e_fv = 0;
            if (m_pend) begin
                m_pend = 0;
                if (m_pend_ok) begin
                    e_fv = 1; e_tv = 1; e_bank = !e_bank;
                    e_s = p_s; e_m = p_m; e_h = p_h; e_d = p_d;
                end
            end
            if (sym_valid) begin
                if (m_st == 0) begin
                    if (sym_code == 2) m_st = 1;
                end else if (m_st == 1) begin
                    if (sym_code == 2) begin
                        m_st = 2; e_ont = 1; q.delete();
                    end else m_st = 0;
                end else begin
                    if (sym_code == 3) m_st = 0;
                    else begin
                        q.push_back(int'(sym_code));
                        if (q.size() == 99) begin
                            evaluate();
                            m_pend = 1;
                            m_st = (sym_code == 2) ? 1 : 0;
                        end
                    end
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(on_time == e_ont, "R2 on_time", int'(on_time), int'(e_ont));
            chk(frame_valid == e_fv, "R6 frame_valid", int'(frame_valid), int'(e_fv));
            chk(held_bank == e_bank, "R6 held_bank", int'(held_bank), int'(e_bank));
            chk(time_valid == e_tv, "R6 time_valid", int'(time_valid), int'(e_tv));
            chk(int'(seconds) == e_s, "R4 seconds", int'(seconds), e_s);
            chk(int'(minutes) == e_m, "R4 minutes", int'(minutes), e_m);
            chk(int'(hours) == e_h, "R4 hours", int'(hours), e_h);
            chk(int'(day_of_year) == e_d, "R4 day", int'(day_of_year), e_d);
            if (frame_valid) fv_seen++;
            if (on_time) ont_seen++;
        end
        if (cycles > 100000) begin
            failures++;
            $display("FAIL R6 watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send(input int c);
        sym_valid = 1'b1;
        sym_code  = 2'(c);
        @(negedge clk);
        if (gap > 0) begin
            sym_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic put(input int pos, input int w, input int v);
        for (int i = 0; i < w; i++) if (((v >> i) & 1) == 1) frm[pos+i] = 1;
    endtask

    task automatic build(input int su, input int st, input int mu, input int mt,
                         input int hu, input int ht, input int du, input int dt, input int dh);
        for (int p = 0; p < 100; p++) frm[p] = (p == 0 || (p % 10) == 9) ? 2 : 0;
        put(1, 4, su); put(6, 3, st); put(10, 4, mu); put(15, 3, mt);
        put(20, 4, hu); put(25, 2, ht); put(30, 4, du); put(35, 4, dt); put(40, 2, dh);
    endtask

    task automatic send_frame();   // reference marker then positions 1..99
        for (int p = 0; p < 100; p++) send(frm[p]);
    endtask

    task automatic settle();
        sym_valid = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic expect_time(input string req, input int s, input int m, input int h, input int d);
        chk(int'(seconds) == s, req, int'(seconds), s);
        chk(int'(minutes) == m, req, int'(minutes), m);
        chk(int'(hours) == h, req, int'(hours), h);
        chk(int'(day_of_year) == d, req, int'(day_of_year), d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(on_time == 0 && frame_valid == 0 && time_valid == 0 && held_bank == 0,
            "R1 reset flags", int'({on_time, frame_valid, time_valid, held_bank}), 0);
        chk(seconds == 0 && minutes == 0 && hours == 0 && day_of_year == 0,
            "R1 reset time", int'(seconds), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: no pairing through a non-marker
        gap = 2;
        send(1); send(0); send(2); send(0); send(1); send(2); send(1);
        settle();
        chk(ont_seen == 0, "R2 lone markers", ont_seen, 0);

        // R2/R4: first frame, 12:34:56 day 123, ones at unused positions 5 and 14
        build(6, 5, 4, 3, 2, 1, 3, 2, 1);
        frm[5] = 1; frm[14] = 1; frm[44] = 1;
        send(2);
        send_frame();
        settle();
        chk(ont_seen == 1, "R2 reference pulse", ont_seen, 1);
        chk(fv_seen == 1, "R6 first strobe", fv_seen, 1);
        expect_time("R4 first frame", 56, 34, 12, 123);
        chk(held_bank == 1, "R6 bank swap", int'(held_bank), 1);
        chk(time_valid == 1, "R6 time_valid", int'(time_valid), 1);

        // R8: chained frame, back-to-back characters, 23:59:59 day 366
        gap = 0;
        build(9, 5, 9, 5, 3, 2, 6, 6, 3);
        send_frame();
        settle();
        chk(ont_seen == 2, "R8 chained reference", ont_seen, 2);
        chk(fv_seen == 2, "R8 chained strobe", fv_seen, 2);
        expect_time("R4 upper bounds", 59, 59, 23, 366);
        chk(held_bank == 0, "R6 bank swap back", int'(held_bank), 0);

        // R3: missing marker, then extra marker
        gap = 1;
        build(1, 0, 1, 0, 1, 0, 1, 0, 0);
        frm[49] = 0;
        send_frame();
        settle();
        build(1, 0, 1, 0, 1, 0, 1, 0, 0);
        frm[27] = 2;
        send_frame();
        settle();
        chk(fv_seen == 2, "R3 marker mismatch discarded", fv_seen, 2);
        expect_time("R3 time held", 59, 59, 23, 366);
        chk(held_bank == 0, "R3 bank held", int'(held_bank), 0);

        // R5: out-of-range digits
        build(0, 6, 0, 0, 0, 0, 1, 0, 0); send_frame(); settle();   // seconds 60
        build(0, 0, 10, 0, 0, 0, 1, 0, 0); send_frame(); settle();  // minute units 10
        build(0, 0, 0, 0, 4, 2, 1, 0, 0); send_frame(); settle();   // hours 24
        build(0, 0, 0, 0, 0, 0, 0, 0, 0); send_frame(); settle();   // day 0
        build(0, 0, 0, 0, 0, 0, 7, 6, 3); send_frame(); settle();   // day 367
        chk(fv_seen == 2, "R5 range violations discarded", fv_seen, 2);
        expect_time("R5 time held", 59, 59, 23, 366);
        chk(ont_seen == 9, "R8 references while discarding", ont_seen, 9);

        // R7: idle mid-frame aborts; idle while hunting ignored
        gap = 2;
        build(9, 0, 8, 0, 7, 0, 5, 4, 0);
        for (int p = 0; p <= 50; p++) send(frm[p]);
        send(3);
        send(3);
        send(1);
        settle();
        chk(fv_seen == 2, "R7 aborted frame", fv_seen, 2);
        send(2);
        send_frame();
        settle();
        chk(fv_seen == 3, "R7 recovery strobe", fv_seen, 3);
        expect_time("R7 recovered time", 9, 8, 7, 45);
        chk(ont_seen == 11, "R2 reference count", ont_seen, 11);
        chk(held_bank == 1, "R6 final bank", int'(held_bank), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule